// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block is the digital timing and level-selection engine for a passive multiplexed LCD. A host fills a small segment data store, one byte per address with two segments per byte. A sequencer walks through the common time slots of each frame, and every common and segment pin gets a 2-bit drive level index on each step. An external resistor ladder or analog switch network turns that index into a voltage. The block offers static drive and 2-, 3- or 4-way multiplexing at one-half or one-third bias.

Each time slot has two half-phases of opposite polarity, so the glass sees no net DC. A single enable input, `frame_tick`, sets the pace: every tick moves to the next half-phase. A mode or enable change is held pending and applied only at a frame boundary, so no partial frame reaches the panel. A 3-bit contrast code is stored and passed on to the analog side. Each step of that code means a further 0.2 V cut in drive voltage, up to 1.4 V at the top code.

Top module: `lcd_mux_drv`

## Requirements
- R1: The 3-bit mode code selects the number of commons and the bias. 000 gives 4 commons at 1/3 bias, 001 gives 3 at 1/3, 010 gives 2 at 1/2, 011 gives 3 at 1/2, and 100 gives static drive (1 common). Codes 101, 110 and 111 behave as static.
- R2: A frame has as many time slots as the active mode has commons. Slots run 0,1,…,N-1 and then wrap. Each slot lasts two frame ticks, so a frame lasts 2·N ticks.
- R3: Polarity toggles on every frame tick. The first half of a slot uses polarity 0 and the second half uses polarity 1. In the second half every level is the mirror of the first half.
- R4: While the active enable is 0, every common level, every segment level and the rail indication are 0 (ground).
- R5: Byte address a holds segment 2a in bits 3:0 and segment 2a+1 in bits 7:4. Within a nibble, bit k is the segment's on state during slot k. Static drive uses bit 0.
- R6: At 1/3 bias with polarity 0, a selected common is at 3 and a non-selected common is at 1. An on segment is at 0 and an off segment is at 2. With polarity 1 these become 0, 2, 3 and 1. The level codes 0 to 3 stand for ground, lowest rail, middle rail and top rail.
- R7: At 1/2 bias and in static drive, a selected common is at 3 with polarity 0 and at 0 with polarity 1. A non-selected common stays at 2. An on segment is at 0/3 and an off segment is at 3/0, for polarity 0/1.
- R8: A configuration write changes mode and enable only at the end of the current frame, which is the tick that ends the last slot's second half. The display never shows a partial frame.
- R9: The contrast code from a configuration write appears on `contrast_code` on the next clock. It does not wait for a frame boundary.
- R10: After reset, all segment bytes, the mode, the enable and the contrast are 0. All drive outputs are 0.
- R11: A host write stores the byte at its address, and `host_rdata` always shows the byte at `host_addr`.
- R12: Common pins beyond the active common count are held at level 0 while enabled.
- R13: While enabled, `rail_on` bit k means the rail for level k+1 is in use. It reads 111 at 1/3 bias, 110 at 1/2 bias and 100 in static drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse that advances one half-phase |
| host_we | input | 1 | Segment byte write strobe |
| host_addr | input | 3 | Segment byte address (NUM_BYTES = 8) |
| host_wdata | input | 8 | Segment byte write data |
| host_rdata | output | 8 | Segment byte at host_addr |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode code (see R1) |
| cfg_enable | input | 1 | Display enable |
| cfg_contrast | input | 3 | Contrast code |
| com_lvl | output | 8 | Level index per common, 2 bits each, common c at bits 2c+1:2c |
| seg_lvl | output | 32 | Level index per segment, 2 bits each, segment j at bits 2j+1:2j |
| rail_on | output | 3 | Bias rails in use (see R13) |
| contrast_code | output | 3 | Registered contrast code |

## Verification
The bench aims at the frame boundary. A mode or enable write sent in the middle of a frame must not show until the wrap, and a design that applied it at once would produce a shortened or mixed frame. Each mode code, including the three undefined ones, is run for a full frame and its period in ticks is measured. A wrong slot count would show up as a com0 pulse at the wrong rate, and treating 101–111 as anything other than static would show up as active extra commons. Mixed bytes with known patterns show whether the two nibbles were swapped or the bits were read in the wrong slot order. The second half-phase is compared against its mirror, which catches a polarity inversion that was left out or applied to only one side.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    localparam int NCOM_MAX   = 4;
    localparam int LVL_W      = 2;
    localparam int MODE_W     = 3;
    localparam int CONTRAST_W = 3;

    localparam logic [MODE_W-1:0] MODE_4C_THIRD  = 3'b000;
    localparam logic [MODE_W-1:0] MODE_3C_THIRD  = 3'b001;
    localparam logic [MODE_W-1:0] MODE_2C_HALF   = 3'b010;
    localparam logic [MODE_W-1:0] MODE_3C_HALF   = 3'b011;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        BIAS_THIRD  = 2'd0,
        BIAS_HALF   = 2'd1,
        BIAS_STATIC = 2'd2
    } bias_e;

    typedef struct packed {
        logic [2:0] ncom;
        bias_e      bias;
    } mode_cfg_t;

    typedef struct packed {
        logic [MODE_W-1:0]     mode;
        logic                  enable;
        logic [CONTRAST_W-1:0] contrast;
    } cfg_word_t;

    localparam lvl_t LVL_GND = 2'd0;
    localparam lvl_t LVL_LOW = 2'd1;
    localparam lvl_t LVL_MID = 2'd2;
    localparam lvl_t LVL_TOP = 2'd3;

    function automatic mode_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        mode_cfg_t r;
        case (m)
            MODE_4C_THIRD: begin r.ncom = 3'd4; r.bias = BIAS_THIRD; end
            MODE_3C_THIRD: begin r.ncom = 3'd3; r.bias = BIAS_THIRD; end
            MODE_2C_HALF:  begin r.ncom = 3'd2; r.bias = BIAS_HALF;  end
            MODE_3C_HALF:  begin r.ncom = 3'd3; r.bias = BIAS_HALF;  end
            default:       begin r.ncom = 3'd1; r.bias = BIAS_STATIC; end
        endcase
        return r;
    endfunction

    function automatic lvl_t com_code(input bias_e b, input logic sel, input logic pol);
        lvl_t v;
        if (sel) begin
            v = pol ? LVL_GND : LVL_TOP;
        end else if (b == BIAS_THIRD) begin
            v = pol ? LVL_MID : LVL_LOW;
        end else begin
            v = LVL_MID;
        end
        return v;
    endfunction

    function automatic lvl_t seg_code(input bias_e b, input logic on, input logic pol);
        lvl_t v;
        if (on) begin
            v = pol ? LVL_TOP : LVL_GND;
        end else if (b == BIAS_THIRD) begin
            v = pol ? LVL_LOW : LVL_MID;
        end else begin
            v = pol ? LVL_GND : LVL_TOP;
        end
        return v;
    endfunction

    function automatic logic [2:0] rails_mask(input bias_e b);
        logic [2:0] r;
        case (b)
            BIAS_THIRD: r = 3'b111;
            BIAS_HALF:  r = 3'b110;
            default:    r = 3'b100;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
    import lcd_drv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [MODE_W-1:0]     cfg_mode,
    input  logic                  cfg_enable,
    input  logic [CONTRAST_W-1:0] cfg_contrast,
    output cfg_word_t             pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (cfg_we) begin
            pend.mode     <= cfg_mode;
            pend.enable   <= cfg_enable;
            pend.contrast <= cfg_contrast;
        end
    end

endmodule

// File: rtl/lcd_seg_store.sv
module lcd_seg_store #(
    parameter int NUM_BYTES = 8,
    localparam int AW       = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int NUM_SEG  = 2 * NUM_BYTES,
    localparam int BITS_W   = NUM_SEG * 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [BITS_W-1:0] seg_bits
);

    logic [7:0] mem [NUM_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                mem[i] <= 8'h00;
            end
        end else if (we && (int'(addr) < NUM_BYTES)) begin
            mem[addr] <= wdata;
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (int'(addr) == i) begin
                rdata = mem[i];
            end
        end
    end

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_flat
        assign seg_bits[b*8 +: 8] = mem[b];
    end

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcd_drv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [MODE_W-1:0] mode_pend,
    input  logic              en_pend,
    output logic [1:0]        slot,
    output logic              pol,
    output logic [MODE_W-1:0] mode_act,
    output logic              en_act,
    output logic              frame_end
);

    mode_cfg_t  cur;
    logic [2:0] last_slot;
    logic       slot_end;

    always_comb begin
        cur       = decode_mode(mode_act);
        last_slot = cur.ncom - 3'd1;
        slot_end  = tick && pol;
        frame_end = slot_end && (slot == last_slot[1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot     <= 2'd0;
            pol      <= 1'b0;
            mode_act <= '0;
            en_act   <= 1'b0;
        end else if (tick) begin
            pol <= ~pol;
            if (frame_end) begin
                slot     <= 2'd0;
                mode_act <= mode_pend;
                en_act   <= en_pend;
            end else if (slot_end) begin
                slot <= slot + 2'd1;
            end
        end
    end

endmodule

// File: rtl/lcd_pin_map.sv
module lcd_pin_map
    import lcd_drv_pkg::*;
#(
    parameter int NUM_SEG = 16
) (
    input  logic [NUM_SEG*4-1:0]     seg_bits,
    input  logic [1:0]               slot,
    input  logic                     pol,
    input  logic [MODE_W-1:0]        mode_act,
    input  logic                     en_act,
    output logic [NCOM_MAX*LVL_W-1:0] com_lvl,
    output logic [NUM_SEG*LVL_W-1:0]  seg_lvl,
    output logic [2:0]               rails
);

    mode_cfg_t cur;
    assign cur   = decode_mode(mode_act);
    assign rails = en_act ? rails_mask(cur.bias) : 3'b000;

    for (genvar c = 0; c < NCOM_MAX; c++) begin : g_com
        logic in_use;
        logic sel;
        assign in_use = (c < int'(cur.ncom));
        assign sel    = (slot == 2'(c));
        assign com_lvl[c*LVL_W +: LVL_W] =
            (en_act && in_use) ? com_code(cur.bias, sel, pol) : LVL_GND;
    end

    for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
        logic [3:0] nib;
        logic       on;
        assign nib = seg_bits[j*4 +: 4];
        assign on  = nib[slot];
        assign seg_lvl[j*LVL_W +: LVL_W] =
            en_act ? seg_code(cur.bias, on, pol) : LVL_GND;
    end

endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv
    import lcd_drv_pkg::*;
#(
    parameter int NUM_BYTES = 8,
    localparam int AW       = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int NUM_SEG  = 2 * NUM_BYTES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_tick,
    input  logic                          host_we,
    input  logic [AW-1:0]                 host_addr,
    input  logic [7:0]                    host_wdata,
    output logic [7:0]                    host_rdata,
    input  logic                          cfg_we,
    input  logic [MODE_W-1:0]             cfg_mode,
    input  logic                          cfg_enable,
    input  logic [CONTRAST_W-1:0]         cfg_contrast,
    output logic [NCOM_MAX*LVL_W-1:0]     com_lvl,
    output logic [NUM_SEG*LVL_W-1:0]      seg_lvl,
    output logic [2:0]                    rail_on,
    output logic [CONTRAST_W-1:0]         contrast_code
);

    cfg_word_t                  pend;
    logic [NUM_SEG*4-1:0]       seg_bits;
    logic [1:0]                 slot_q;
    logic                       pol_q;
    logic [MODE_W-1:0]          mode_act;
    logic                       en_act;
    logic                       frame_end;
    logic [NCOM_MAX*LVL_W-1:0]  com_nxt;
    logic [NUM_SEG*LVL_W-1:0]   seg_nxt;
    logic [2:0]                 rails_nxt;

    lcd_cfg_regs u_cfg (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_mode     (cfg_mode),
        .cfg_enable   (cfg_enable),
        .cfg_contrast (cfg_contrast),
        .pend         (pend)
    );

    lcd_seg_store #(.NUM_BYTES(NUM_BYTES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (host_we),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .rdata    (host_rdata),
        .seg_bits (seg_bits)
    );

    lcd_frame_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (frame_tick),
        .mode_pend (pend.mode),
        .en_pend   (pend.enable),
        .slot      (slot_q),
        .pol       (pol_q),
        .mode_act  (mode_act),
        .en_act    (en_act),
        .frame_end (frame_end)
    );

    lcd_pin_map #(.NUM_SEG(NUM_SEG)) u_map (
        .seg_bits (seg_bits),
        .slot     (slot_q),
        .pol      (pol_q),
        .mode_act (mode_act),
        .en_act   (en_act),
        .com_lvl  (com_nxt),
        .seg_lvl  (seg_nxt),
        .rails    (rails_nxt)
    );

    assign contrast_code = pend.contrast;

    always_ff @(posedge clk) begin
        if (rst) begin
            com_lvl <= '0;
            seg_lvl <= '0;
            rail_on <= 3'b000;
        end else begin
            com_lvl <= com_nxt;
            seg_lvl <= seg_nxt;
            rail_on <= rails_nxt;
        end
    end

endmodule

// File: rtl/lcd_mux_drv_chk.sv
module lcd_mux_drv_chk
    import lcd_drv_pkg::*;
#(
    parameter int NUM_SEG = 16
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          frame_tick,
    input logic                          cfg_we,
    input logic [CONTRAST_W-1:0]         cfg_contrast,
    input logic [1:0]                    slot_q,
    input logic                          pol_q,
    input logic [MODE_W-1:0]             mode_act,
    input logic                          en_act,
    input logic                          frame_end,
    input logic [NCOM_MAX*LVL_W-1:0]     com_lvl,
    input logic [NUM_SEG*LVL_W-1:0]      seg_lvl,
    input logic [2:0]                    rail_on,
    input logic [CONTRAST_W-1:0]         contrast_code
);

    mode_cfg_t act_cfg;
    assign act_cfg = decode_mode(mode_act);

    // R4
    disabled_ground_chk: assert property (@(posedge clk) disable iff (rst)
        !en_act |=> (com_lvl == '0 && seg_lvl == '0 && rail_on == 3'b000));

    // R3
    pol_flip_chk: assert property (@(posedge clk) disable iff (rst)
        frame_tick |=> (pol_q != $past(pol_q)));

    // R2
    slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, slot_q} < act_cfg.ncom));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> ($stable(mode_act) && $stable(en_act)));

    // R9
    contrast_pass_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (contrast_code == $past(cfg_contrast)));

    // R12
    unused_com_chk: assert property (@(posedge clk) disable iff (rst)
        (en_act && act_cfg.ncom < 3'd4) |=> (com_lvl[7:6] == LVL_GND));

endmodule

bind lcd_mux_drv lcd_mux_drv_chk #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_tick    (frame_tick),
    .cfg_we        (cfg_we),
    .cfg_contrast  (cfg_contrast),
    .slot_q        (slot_q),
    .pol_q         (pol_q),
    .mode_act      (mode_act),
    .en_act        (en_act),
    .frame_end     (frame_end),
    .com_lvl       (com_lvl),
    .seg_lvl       (seg_lvl),
    .rail_on       (rail_on),
    .contrast_code (contrast_code)
);

// File: tb/lcd_mux_drv_tb_top.sv
module lcd_mux_drv_tb_top;

    localparam int NB  = 8;
    localparam int NS  = 2 * NB;
    localparam int AW  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_tick = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_mode = '0;
    logic          cfg_enable = 1'b0;
    logic [2:0]    cfg_contrast = '0;
    logic [7:0]    com_lvl;
    logic [NS*2-1:0] seg_lvl;
    logic [2:0]    rail_on;
    logic [2:0]    contrast_code;

    always #5 clk = ~clk;

    lcd_mux_drv #(.NUM_BYTES(NB)) dut_i (
        .clk(clk), .rst(rst), .frame_tick(frame_tick),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_enable(cfg_enable), .cfg_contrast(cfg_contrast),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl), .rail_on(rail_on),
        .contrast_code(contrast_code)
    );

    int   n_vec = 0;
    int   n_bad = 0;
    bit   finished = 0;

    // bench model state
    logic [7:0] m_mem [NB];
    int   m_slot = 0;
    int   m_pol  = 0;
    int   m_mode = 0;
    int   m_en   = 0;
    int   p_mode = 0;
    int   p_en   = 0;
    int   m_con  = 0;

    function automatic int ncom_of(input int m);
        case (m)
            0: return 4;
            1: return 3;
            2: return 2;
            3: return 3;
            default: return 1;
        endcase
    endfunction

    // 0 = one-third, 1 = one-half, 2 = static
    function automatic int bias_of(input int m);
        if (m <= 1) return 0;
        if (m <= 3) return 1;
        return 2;
    endfunction

    function automatic logic [7:0] exp_com();
        logic [7:0] v = '0;
        for (int c = 0; c < 4; c++) begin
            int lv = 0;
            if (m_en != 0 && c < ncom_of(m_mode)) begin
                if (c == m_slot) lv = (m_pol != 0) ? 0 : 3;
                else if (bias_of(m_mode) == 0) lv = (m_pol != 0) ? 2 : 1;
                else lv = 2;
            end
            v[c*2 +: 2] = 2'(lv);
        end
        return v;
    endfunction

    function automatic logic [NS*2-1:0] exp_seg();
        logic [NS*2-1:0] v = '0;
        for (int j = 0; j < NS; j++) begin
            int  lv = 0;
            bit  on;
            on = m_mem[j/2][(j%2)*4 + m_slot];
            if (m_en != 0) begin
                if (on) lv = (m_pol != 0) ? 3 : 0;
                else if (bias_of(m_mode) == 0) lv = (m_pol != 0) ? 1 : 2;
                else lv = (m_pol != 0) ? 0 : 3;
            end
            v[j*2 +: 2] = 2'(lv);
        end
        return v;
    endfunction

    function automatic logic [2:0] exp_rails();
        if (m_en == 0) return 3'b000;
        case (bias_of(m_mode))
            0: return 3'b111;
            1: return 3'b110;
            default: return 3'b100;
        endcase
    endfunction

    function automatic string lvl_tag();
        if (m_en == 0) return "R4";
        if (bias_of(m_mode) == 0) return "R6";
        return "R7";
    endfunction

    task automatic check_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        check_val(tag, 64'(com_lvl), 64'(exp_com()));
        check_val(tag, 64'(seg_lvl), 64'(exp_seg()));
        check_val("R13", 64'(rail_on), 64'(exp_rails()));
    endtask

    task automatic model_tick();
        if (m_pol != 0) begin
            if (m_slot == ncom_of(m_mode) - 1) begin
                m_slot = 0;
                m_mode = p_mode;
                m_en   = p_en;
            end else begin
                m_slot++;
            end
        end
        m_pol = 1 - m_pol;
    endtask

    task automatic do_tick();
        @(negedge clk);
        frame_tick = 1'b1;
        model_tick();
        @(negedge clk);
        frame_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_write(input int a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
        m_mem[a] = d;
        @(negedge clk);
        host_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic cfg_write(input int md, input int en, input int con);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = 3'(md); cfg_enable = 1'(en); cfg_contrast = 3'(con);
        p_mode = md; p_en = en; m_con = con;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic to_frame_start();
        for (int k = 0; k < 16; k++) begin
            if (m_slot == 0 && m_pol == 0 && m_mode == p_mode && m_en == p_en) break;
            do_tick();
        end
    endtask

    initial begin
        for (int i = 0; i < NB; i++) m_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        check_val("R10", 64'(com_lvl), 64'd0);
        check_val("R10", 64'(seg_lvl), 64'd0);
        check_val("R10", 64'(rail_on), 64'd0);
        check_val("R10", 64'(contrast_code), 64'd0);
        host_addr = 3'd5;
        @(negedge clk);
        check_val("R10", 64'(host_rdata), 64'd0);

        // R11: write then read back
        for (int a = 0; a < NB; a++) host_write(a, 8'(8'h11 * (a + 1) ^ 8'h5A));
        for (int a = 0; a < NB; a++) begin
            @(negedge clk);
            host_addr = AW'(a);
            @(negedge clk);
            check_val("R11", 64'(host_rdata), 64'(m_mem[a]));
        end

        // R9: contrast codes
        for (int c = 0; c < 8; c++) begin
            cfg_write(0, 0, c);
            check_val("R9", 64'(contrast_code), 64'(c));
        end

        // R8: enable is held pending until frame wraps
        cfg_write(0, 1, 3);
        check_outs("R8");
        check_val("R8", 64'(rail_on), 64'd0);
        to_frame_start();
        check_val("R8", 64'(rail_on), 64'b111);

        // R5: known nibble patterns, walked across a 4-common frame
        host_write(1, 8'hA5);
        host_write(6, 8'h3C);
        for (int k = 0; k < 8; k++) begin
            check_outs("R5");
            check_val("R5", 64'(seg_lvl[5:4]), 64'((m_pol != 0) ? ((m_slot % 2 == 0) ? 3 : 1) : ((m_slot % 2 == 0) ? 0 : 2)));
            do_tick();
        end

        // R3: mid-frame switch request; R8 old mode stays until wrap
        do_tick(); do_tick();
        cfg_write(4, 0, 3);
        for (int k = 0; k < 6; k++) begin
            check_outs("R8");
            check_val("R8", 64'(rail_on), 64'b111);
            do_tick();
        end
        check_outs("R4");
        check_val("R4", 64'(com_lvl), 64'd0);
        check_val("R4", 64'(seg_lvl), 64'd0);

        // R1 / R2 / R12 / R13: every mode code, frame period measured on com0
        for (int md = 0; md < 8; md++) begin
            int period;
            cfg_write(md, 1, 2);
            to_frame_start();
            check_outs("R2");
            check_val("R13", 64'(rail_on), 64'(exp_rails()));
            period = 0;
            for (int k = 0; k < 12; k++) begin
                do_tick();
                period++;
                check_outs("R3");
                if (ncom_of(md) < 4)
                    check_val("R12", 64'(com_lvl[7:6]), 64'd0);
                if (com_lvl[1:0] == 2'd3) break;
            end
            check_val("R1", 64'(period), 64'(2 * ncom_of(md)));
        end

        // constrained random phase
        void'($urandom(32'd20240611));
        for (int s = 0; s < 2500; s++) begin
            int r = int'($urandom % 10);
            if (r < 2) begin
                host_write(int'($urandom % NB), 8'($urandom));
            end else if (r == 2) begin
                cfg_write(int'($urandom % 8), ($urandom % 4 != 0) ? 1 : 0, int'($urandom % 8));
                check_val("R9", 64'(contrast_code), 64'(m_con));
            end else begin
                do_tick();
            end
            check_outs(lvl_tag());
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule